// File: doc/BRIEF.md
# Write-Back Data Cache with Store Buffer

This block sits between a processor load/store port and a memory interface that can move a whole line in one burst. It is direct-mapped: eight lines of four 32-bit words, each line with a valid bit and a dirty bit. A cached load that hits is answered in the next cycle and never reaches memory. A cached load that misses fetches the whole line with one burst read and returns the requested word once the line is in place.

Cached stores go into a two-entry store buffer, so the core can keep issuing work while a line is being fetched. The buffer drains one entry at a time in order. If the target line of an entry is absent, that line is first filled by a burst read, so the bytes the store does not touch are kept. The entry is then merged under its byte enables and the line is marked dirty. Modified lines go back to memory only when another access evicts them, always as a burst write, and always before the refill burst for the new line. An uncached request skips the cache and the store buffer and makes a single-beat memory access.

Top module: `dcache_wb`

## Requirements
- R1: A cached load that hits is accepted and answered with rsp_valid in the very next cycle. It issues no memory command.
- R2: A cached load miss issues exactly one read command with mem_cmd_burst=1 (four beats) at the line-aligned address. The command is held until accepted. The four beats fill line words 0, 1, 2, 3 in ascending order, and after the last beat the requested word is returned.
- R3: The store buffer holds two entries. A cached store is accepted whenever fewer than two entries are pending, including while a line fill is in progress. req_ready is low for a cached store while both entries are pending.
- R4: A buffered store whose line is not resident first triggers a burst read of that line. Its bytes are then merged: req_be bit i selects data bits 8i+7..8i, and the unselected bytes keep their memory values.
- R5: Modified data reaches memory only when its line is evicted, as one burst write of the victim's four words to the victim's line address. Evicting a clean line writes nothing.
- R6: When the victim is dirty, its burst write command and all of its beats complete before the refill read command is issued.
- R7: A load to a word that has a pending store-buffer entry is not answered until that entry has merged. A load never returns data older than the last store accepted to the same address.
- R8: An uncached request waits until the store buffer is empty. It then issues one command with mem_cmd_burst=0 at its word address and makes one data beat. It neither allocates nor evicts a line: a later cached load of a resident line still hits.
- R9: After reset no line is valid and the store buffer is empty, so the first cached load misses. No command, write beat or response is driven until a request arrives.
- R10: Every beat of a burst write carries mem_wstrb=4'b1111. The beat of an uncached write carries the request's req_be.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_write | input | 1 | 1 = store, 0 = load |
| req_uncached | input | 1 | 1 = bypass cache and store buffer |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Store data |
| req_be | input | 4 | Store byte enables, bit i for byte i |
| rsp_valid | output | 1 | Load data valid (one-cycle pulse) |
| rsp_rdata | output | 32 | Load data |
| mem_cmd_valid | output | 1 | Memory command valid |
| mem_cmd_ready | input | 1 | Memory command accepted |
| mem_cmd_write | output | 1 | 1 = write command |
| mem_cmd_burst | output | 1 | 1 = four-beat line burst, 0 = single beat |
| mem_cmd_addr | output | 32 | Command address (line-aligned for bursts) |
| mem_wvalid | output | 1 | Write beat valid |
| mem_wready | input | 1 | Write beat accepted |
| mem_wdata | output | 32 | Write beat data |
| mem_wstrb | output | 4 | Write beat byte strobes |
| mem_rvalid | input | 1 | Read beat valid (no back-pressure) |
| mem_rdata | input | 32 | Read beat data |

## Verification
The assertions assume that the memory side returns read beats only after a read command has been accepted, and exactly as many beats as that command asked for. They also assume that write beats are counted against the command that preceded them. They further assume that cached and uncached accesses never touch the same addresses, because the block keeps no coherence between the two paths. The stimulus drives memory from a model that answers each command in order, with one beat per cycle and an exact beat count. Uncached traffic stays in an upper address region that cached traffic never uses.

// File: rtl/dcache_wb.sv
module dcache_wb #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int NUM_LINES  = 8,
  parameter int LINE_WORDS = 4,
  parameter int SB_DEPTH   = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic                   req_uncached,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [DATA_W-1:0]      req_wdata,
  input  logic [DATA_W/8-1:0]    req_be,
  output logic                   rsp_valid,
  output logic [DATA_W-1:0]      rsp_rdata,
  output logic                   mem_cmd_valid,
  input  logic                   mem_cmd_ready,
  output logic                   mem_cmd_write,
  output logic                   mem_cmd_burst,
  output logic [ADDR_W-1:0]      mem_cmd_addr,
  output logic                   mem_wvalid,
  input  logic                   mem_wready,
  output logic [DATA_W-1:0]      mem_wdata,
  output logic [DATA_W/8-1:0]    mem_wstrb,
  input  logic                   mem_rvalid,
  input  logic [DATA_W-1:0]      mem_rdata
);

  localparam int BE_W   = DATA_W / 8;
  localparam int BYTE_W = $clog2(BE_W);
  localparam int OFS_W  = $clog2(LINE_WORDS);
  localparam int IDX_W  = $clog2(NUM_LINES);
  localparam int WA_W   = ADDR_W - BYTE_W;
  localparam int TAG_W  = WA_W - OFS_W - IDX_W;
  localparam int SBP_W  = (SB_DEPTH > 1) ? $clog2(SB_DEPTH) : 1;
  localparam int SLOTS  = NUM_LINES * LINE_WORDS;

  typedef enum logic [2:0] {
    S_IDLE, S_WB_CMD, S_WB_DAT, S_RF_CMD, S_RF_DAT, S_UC_CMD, S_UC_WR, S_UC_RD
  } st_t;

  st_t st;

  logic [DATA_W-1:0] data_q [SLOTS];
  logic [TAG_W-1:0]  tag_q  [NUM_LINES];
  logic [NUM_LINES-1:0] vld_q, dty_q;

  logic [WA_W-1:0]   sb_wa [SB_DEPTH];
  logic [DATA_W-1:0] sb_d  [SB_DEPTH];
  logic [BE_W-1:0]   sb_be [SB_DEPTH];
  logic [SB_DEPTH-1:0] sb_vld;
  logic [SBP_W-1:0]  sb_wp, sb_rp;

  logic [WA_W-1:0]   fl_wa;
  logic              fl_ld;
  logic [OFS_W-1:0]  beat;
  logic [WA_W-1:0]   uc_wa;
  logic              uc_wr;
  logic [DATA_W-1:0] uc_d;
  logic [BE_W-1:0]   uc_be;

  function automatic logic [SBP_W-1:0] ptr_inc(input logic [SBP_W-1:0] p);
    return (p == SBP_W'(SB_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic unused_lo;
  assign unused_lo = ^req_addr[BYTE_W-1:0];

  wire [WA_W-1:0]  req_wa  = req_addr[ADDR_W-1:BYTE_W];
  wire [IDX_W-1:0] req_idx = req_wa[OFS_W +: IDX_W];
  wire [TAG_W-1:0] req_tag = req_wa[WA_W-1 -: TAG_W];
  wire [OFS_W-1:0] req_wrd = req_wa[OFS_W-1:0];
  wire             req_hit = vld_q[req_idx] && (tag_q[req_idx] == req_tag);

  wire [WA_W-1:0]  hd_wa  = sb_wa[sb_rp];
  wire [IDX_W-1:0] hd_idx = hd_wa[OFS_W +: IDX_W];
  wire [TAG_W-1:0] hd_tag = hd_wa[WA_W-1 -: TAG_W];
  wire [OFS_W-1:0] hd_wrd = hd_wa[OFS_W-1:0];
  wire             hd_vld = sb_vld[sb_rp];
  wire             hd_hit = vld_q[hd_idx] && (tag_q[hd_idx] == hd_tag);

  wire [IDX_W-1:0] fl_idx = fl_wa[OFS_W +: IDX_W];
  wire [TAG_W-1:0] fl_tag = fl_wa[WA_W-1 -: TAG_W];
  wire [OFS_W-1:0] fl_wrd = fl_wa[OFS_W-1:0];

  wire sb_empty = ~|sb_vld;
  wire sb_full  = &sb_vld;
  wire idle     = (st == S_IDLE);
  wire last     = (beat == OFS_W'(LINE_WORDS - 1));

  logic hazard;
  always_comb begin
    hazard = 1'b0;
    for (int i = 0; i < SB_DEPTH; i++)
      if (sb_vld[i] && sb_wa[i] == req_wa) hazard = 1'b1;
  end

  always_comb begin
    if (req_uncached)   req_ready = idle && sb_empty;
    else if (req_write) req_ready = !sb_full;
    else                req_ready = idle && !hazard && (req_hit || sb_empty);
  end

  wire acc    = req_valid && req_ready;
  wire acc_ld = acc && !req_write && !req_uncached;
  wire acc_st = acc && req_write && !req_uncached;
  wire acc_uc = acc && req_uncached;

  wire drain   = idle && hd_vld && hd_hit;
  wire hd_miss = idle && hd_vld && !hd_hit;
  wire fl_go   = hd_miss || (acc_ld && !req_hit);

  wire [WA_W-1:0]  go_wa  = hd_miss ? hd_wa : req_wa;
  wire [IDX_W-1:0] go_idx = go_wa[OFS_W +: IDX_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      vld_q     <= '0;
      dty_q     <= '0;
      sb_vld    <= '0;
      sb_wp     <= '0;
      sb_rp     <= '0;
      beat      <= '0;
      fl_ld     <= 1'b0;
      rsp_valid <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;

      if (acc_st) begin
        sb_vld[sb_wp] <= 1'b1;
        sb_wa[sb_wp]  <= req_wa;
        sb_d[sb_wp]   <= req_wdata;
        sb_be[sb_wp]  <= req_be;
        sb_wp         <= ptr_inc(sb_wp);
      end

      case (st)
        S_IDLE: begin
          if (drain) begin
            for (int b = 0; b < BE_W; b++)
              if (sb_be[sb_rp][b])
                data_q[{hd_idx, hd_wrd}][8*b +: 8] <= sb_d[sb_rp][8*b +: 8];
            dty_q[hd_idx] <= 1'b1;
            sb_vld[sb_rp] <= 1'b0;
            sb_rp         <= ptr_inc(sb_rp);
          end
          if (acc_ld && req_hit) begin
            rsp_valid <= 1'b1;
            rsp_rdata <= data_q[{req_idx, req_wrd}];
          end
          if (fl_go) begin
            fl_wa <= go_wa;
            fl_ld <= !hd_miss;
            beat  <= '0;
            st    <= (vld_q[go_idx] && dty_q[go_idx]) ? S_WB_CMD : S_RF_CMD;
          end
          if (acc_uc) begin
            uc_wa <= req_wa;
            uc_wr <= req_write;
            uc_d  <= req_wdata;
            uc_be <= req_be;
            st    <= S_UC_CMD;
          end
        end
        S_WB_CMD: if (mem_cmd_ready) st <= S_WB_DAT;
        S_WB_DAT: if (mem_wready) begin
          beat <= beat + 1'b1;
          if (last) st <= S_RF_CMD;
        end
        S_RF_CMD: if (mem_cmd_ready) st <= S_RF_DAT;
        S_RF_DAT: if (mem_rvalid) begin
          data_q[{fl_idx, beat}] <= mem_rdata;
          if (fl_ld && beat == fl_wrd) rsp_rdata <= mem_rdata;
          beat <= beat + 1'b1;
          if (last) begin
            vld_q[fl_idx] <= 1'b1;
            dty_q[fl_idx] <= 1'b0;
            tag_q[fl_idx] <= fl_tag;
            rsp_valid     <= fl_ld;
            st            <= S_IDLE;
          end
        end
        S_UC_CMD: if (mem_cmd_ready) st <= uc_wr ? S_UC_WR : S_UC_RD;
        S_UC_WR:  if (mem_wready) st <= S_IDLE;
        S_UC_RD:  if (mem_rvalid) begin
          rsp_valid <= 1'b1;
          rsp_rdata <= mem_rdata;
          st        <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  localparam int LO_W = OFS_W + BYTE_W;

  assign mem_cmd_valid = (st == S_WB_CMD) || (st == S_RF_CMD) || (st == S_UC_CMD);
  assign mem_cmd_write = (st == S_WB_CMD) || ((st == S_UC_CMD) && uc_wr);
  assign mem_cmd_burst = (st != S_UC_CMD);

  always_comb begin
    case (st)
      S_WB_CMD: mem_cmd_addr = {tag_q[fl_idx], fl_idx, {LO_W{1'b0}}};
      S_UC_CMD: mem_cmd_addr = {uc_wa, {BYTE_W{1'b0}}};
      default:  mem_cmd_addr = {fl_tag, fl_idx, {LO_W{1'b0}}};
    endcase
  end

  assign mem_wvalid = (st == S_WB_DAT) || (st == S_UC_WR);
  assign mem_wdata  = (st == S_UC_WR) ? uc_d  : data_q[{fl_idx, beat}];
  assign mem_wstrb  = (st == S_UC_WR) ? uc_be : {BE_W{1'b1}};

endmodule

// File: rtl/dcache_wb_chk.sv
module dcache_wb_chk #(
  parameter int ADDR_W     = 32,
  parameter int BE_W       = 4,
  parameter int LINE_WORDS = 4,
  parameter int SB_DEPTH   = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                req_ready,
  input logic                req_write,
  input logic                req_uncached,
  input logic [SB_DEPTH-1:0] sb_vld,
  input logic                mem_cmd_valid,
  input logic                mem_cmd_ready,
  input logic                mem_cmd_write,
  input logic                mem_cmd_burst,
  input logic [ADDR_W-1:0]   mem_cmd_addr,
  input logic                mem_wvalid,
  input logic                mem_wready,
  input logic [BE_W-1:0]     mem_wstrb
);
  localparam int LINE_LO = $clog2(LINE_WORDS * BE_W);
  localparam int WORD_LO = $clog2(BE_W);
  localparam int CNT_W   = $clog2(LINE_WORDS + 1);

  logic [CNT_W-1:0] wb_left;
  logic             wr_burst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_left  <= '0;
      wr_burst <= 1'b0;
    end else if (mem_cmd_valid && mem_cmd_ready && mem_cmd_write) begin
      wb_left  <= mem_cmd_burst ? CNT_W'(LINE_WORDS) : CNT_W'(1);
      wr_burst <= mem_cmd_burst;
    end else if (mem_wvalid && mem_wready && wb_left != '0) begin
      wb_left <= wb_left - 1'b1;
    end
  end

  // R2
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cmd_valid && !mem_cmd_ready |=> mem_cmd_valid && $stable(mem_cmd_addr) && $stable(mem_cmd_write));

  // R2
  burst_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cmd_valid && mem_cmd_burst |-> mem_cmd_addr[LINE_LO-1:0] == '0);

  // R8
  single_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cmd_valid && !mem_cmd_burst |-> mem_cmd_addr[WORD_LO-1:0] == '0);

  // R6
  wb_before_refill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_left != '0 |-> !mem_cmd_valid);

  // R5
  wbeat_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wvalid |-> wb_left != '0);

  // R10
  burst_strb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wvalid && wr_burst |-> mem_wstrb == {BE_W{1'b1}});

  // R3
  sb_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write && !req_uncached && (&sb_vld) |-> !req_ready);
endmodule

bind dcache_wb dcache_wb_chk #(
  .ADDR_W(ADDR_W), .BE_W(BE_W), .LINE_WORDS(LINE_WORDS), .SB_DEPTH(SB_DEPTH)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
  .req_uncached(req_uncached), .sb_vld(sb_vld),
  .mem_cmd_valid(mem_cmd_valid), .mem_cmd_ready(mem_cmd_ready),
  .mem_cmd_write(mem_cmd_write), .mem_cmd_burst(mem_cmd_burst),
  .mem_cmd_addr(mem_cmd_addr), .mem_wvalid(mem_wvalid),
  .mem_wready(mem_wready), .mem_wstrb(mem_wstrb)
);

// File: tb/test_dcache_wb.sv
`timescale 1ns/1ps
module test_dcache_wb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        req_valid = 1'b0, req_write = 1'b0, req_uncached = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic [3:0]  req_be = '0;
  logic        req_ready, rsp_valid;
  logic [31:0] rsp_rdata;
  logic        mem_cmd_valid, mem_cmd_write, mem_cmd_burst;
  logic [31:0] mem_cmd_addr;
  logic        mem_wvalid;
  logic [31:0] mem_wdata;
  logic [3:0]  mem_wstrb;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;

  dcache_wb i_dcache_wb (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_uncached(req_uncached), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_be(req_be), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_cmd_valid(mem_cmd_valid), .mem_cmd_ready(1'b1),
    .mem_cmd_write(mem_cmd_write), .mem_cmd_burst(mem_cmd_burst),
    .mem_cmd_addr(mem_cmd_addr), .mem_wvalid(mem_wvalid), .mem_wready(1'b1),
    .mem_wdata(mem_wdata), .mem_wstrb(mem_wstrb),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  int nchk = 0, nfail = 0;
  logic [31:0] bmem [1024];
  logic [31:0] gmem [1024];
  logic [31:0] exp_q [$];
  string       tag_q [$];
  int          lg_kind [$];
  logic [31:0] lg_addr [$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] seed(input int i);
    return (i * 32'h9E3779B1) ^ 32'hC3A5_0000;
  endfunction

  // memory model: sees each handshake at the negedge before the edge that completes it
  int rd_left = 0, rd_wa = 0, wr_wa = 0;
  bit wr_is_burst = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_rvalid = 1'b0; rd_left = 0;
    end else begin
      if (rd_left > 0) begin
        mem_rvalid = 1'b1; mem_rdata = bmem[rd_wa & 1023];
        rd_wa++; rd_left--;
      end else mem_rvalid = 1'b0;
      if (mem_wvalid) begin
        if (wr_is_burst) chk(mem_wstrb == 4'hF, "R10 burst strobe", {28'd0, mem_wstrb}, 32'hF);
        for (int b = 0; b < 4; b++)
          if (mem_wstrb[b]) bmem[wr_wa & 1023][8*b +: 8] = mem_wdata[8*b +: 8];
        wr_wa++;
      end
      if (mem_cmd_valid) begin
        lg_kind.push_back((mem_cmd_write ? 1 : 0) + (mem_cmd_burst ? 0 : 2));
        lg_addr.push_back(mem_cmd_addr);
        if (mem_cmd_write) begin
          wr_wa = int'(mem_cmd_addr >> 2); wr_is_burst = mem_cmd_burst;
        end else begin
          rd_wa = int'(mem_cmd_addr >> 2); rd_left = mem_cmd_burst ? 4 : 1;
        end
      end
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) chk(1'b0, "R1 unexpected response", rsp_rdata, 32'h0);
      else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        chk(rsp_rdata == e, t, rsp_rdata, e);
      end
    end
  end

  task automatic access(input bit wr, input bit unc, input logic [31:0] a,
                        input logic [31:0] d, input logic [3:0] be, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_uncached = unc;
    req_addr = a; req_wdata = d; req_be = be;
    #1;
    while (!req_ready) begin
      @(negedge clk); #1;
    end
    @(posedge clk);
    if (wr) begin
      for (int b = 0; b < 4; b++) if (be[b]) gmem[a[11:2]][8*b +: 8] = d[8*b +: 8];
    end else begin
      exp_q.push_back(gmem[a[11:2]]); tag_q.push_back(tag);
    end
    #1 req_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (30) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int n;
    for (int i = 0; i < 1024; i++) begin bmem[i] = seed(i); gmem[i] = seed(i); end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R9 reset state
    chk(!rsp_valid && !mem_cmd_valid && !mem_wvalid, "R9 idle after reset",
        {29'd0, rsp_valid, mem_cmd_valid, mem_wvalid}, 32'h0);
    chk(lg_kind.size() == 0, "R9 no command after reset", lg_kind.size(), 0);

    // R2 first load misses: one line burst, requested word returned
    access(0, 0, 32'h104, 0, 0, "R2 miss data");
    settle();
    chk(lg_kind.size() == 1, "R9 first load misses", lg_kind.size(), 1);
    chk(lg_kind[0] == 0 && lg_addr[0] == 32'h100, "R2 burst read at line address", lg_addr[0], 32'h100);

    // R1 hits: next-cycle response, no memory traffic; ascending fill order (R2)
    n = lg_kind.size();
    access(0, 0, 32'h100, 0, 0, "R2 word0 ascending");
    @(negedge clk); chk(rsp_valid == 1'b1, "R1 next-cycle response", rsp_valid, 1);
    access(0, 0, 32'h108, 0, 0, "R2 word2 ascending");
    access(0, 0, 32'h10C, 0, 0, "R2 word3 ascending");
    settle();
    chk(lg_kind.size() == n, "R1 hit makes no command", lg_kind.size(), n);

    // R4 store to absent line: clean victim (R5), fill, merge
    n = lg_kind.size();
    access(1, 0, 32'h204, 32'h0000_AB00, 4'b0010, "R4");
    settle();
    chk(lg_kind.size() == n + 1 && lg_kind[n] == 0 && lg_addr[n] == 32'h200,
        "R4 store allocates by burst read", lg_addr[n], 32'h200);
    chk(lg_kind.size() == n + 1, "R5 clean victim not written", lg_kind.size(), n + 1);
    access(0, 0, 32'h204, 0, 0, "R4 merged bytes");
    settle();
    chk(bmem[32'h204 >> 2] == seed(32'h204 >> 2), "R5 dirty data held until eviction",
        bmem[32'h204 >> 2], seed(32'h204 >> 2));

    // R5/R6 dirty eviction: burst write of victim, then refill
    n = lg_kind.size();
    access(0, 0, 32'h188, 0, 0, "R2 miss after eviction");
    settle();
    chk(lg_kind.size() == n + 2, "R6 two commands", lg_kind.size(), n + 2);
    chk(lg_kind[n] == 1 && lg_addr[n] == 32'h200, "R6 write-back first", lg_addr[n], 32'h200);
    chk(lg_kind[n+1] == 0 && lg_addr[n+1] == 32'h180, "R6 refill second", lg_addr[n+1], 32'h180);
    for (int w = 0; w < 4; w++)
      chk(bmem[(32'h200 >> 2) + w] == gmem[(32'h200 >> 2) + w], "R5 evicted line in memory",
          bmem[(32'h200 >> 2) + w], gmem[(32'h200 >> 2) + w]);

    // R3 buffer fills while a line is fetched
    access(1, 0, 32'h300, 32'h1122_3344, 4'b1111, "R3");
    access(1, 0, 32'h314, 32'h5566_7788, 4'b0101, "R3");
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_uncached = 1'b0;
    req_addr = 32'h328; req_wdata = 32'h99AA_BBCC; req_be = 4'b1000;
    #1 chk(req_ready == 1'b0, "R3 full buffer refuses store", req_ready, 0);
    req_valid = 1'b0;
    access(1, 0, 32'h328, 32'h99AA_BBCC, 4'b1000, "R3");
    settle();
    access(0, 0, 32'h300, 0, 0, "R4 full-word merge");
    access(0, 0, 32'h314, 0, 0, "R4 partial merge");
    access(0, 0, 32'h328, 0, 0, "R4 top-byte merge");
    settle();

    // R7 load right after store to a pending address
    access(1, 0, 32'h380, 32'hDEAD_BEEF, 4'b1111, "R7");
    access(0, 0, 32'h380, 0, 0, "R7 no stale data");
    access(0, 0, 32'h384, 0, 0, "R7 neighbour word");
    settle();

    // R8/R10 uncached bypass
    n = lg_kind.size();
    access(1, 1, 32'h804, 32'hA1B2_C3D4, 4'b1100, "R8");
    settle();
    chk(lg_kind.size() == n + 1 && lg_kind[n] == 3 && lg_addr[n] == 32'h804,
        "R8 single-beat write", lg_addr[n], 32'h804);
    chk(bmem[32'h804 >> 2] == gmem[32'h804 >> 2], "R10 single write uses byte enables",
        bmem[32'h804 >> 2], gmem[32'h804 >> 2]);
    access(0, 1, 32'h804, 0, 0, "R8 uncached read");
    access(0, 1, 32'h90C, 0, 0, "R8 uncached read 2");
    settle();
    chk(lg_kind.size() == n + 3 && lg_kind[n+1] == 2 && lg_kind[n+2] == 2,
        "R8 single-beat reads", lg_kind.size(), n + 3);
    n = lg_kind.size();
    access(0, 0, 32'h38C, 0, 0, "R8 resident line kept");
    settle();
    chk(lg_kind.size() == n, "R8 no allocation by bypass", lg_kind.size(), n);

    chk(exp_q.size() == 0, "R1 all responses returned", exp_q.size(), 0);
    finish_run();
  end
endmodule